// File: doc/BRIEF.md
# Power-Up Reset Sequencer with Cause Flags

This block generates the internal reset of a small processor core. A digital power-on pulse, a brown-out detect level, an active-low master-clear pin and a few configuration inputs go in, and a single core reset comes out. When the power-on pulse ends, an optional power-up delay runs, counted in slow timer ticks. In crystal clock modes an oscillator start-up stage follows it, counted in oscillator-cycle strobes. The delays are measured from the power-on event and not from the release of master-clear. If master-clear is held low for longer than both delays, raising it starts the core at once.

Software can read and write a two-bit reset-cause register. The power-on flag is cleared only by a power-on reset, and the brown-out flag is cleared only by a brown-out reset. Software sets each flag to 1 after it has read it. On a later reset it can then tell which kind of event occurred. The register is accessed through a plain write strobe and a read bus. There is no handshake, because every access completes in one cycle.

Top module: `rst_seq_top`

## Requirements
- R1: `core_rst_o` is 1 in any cycle where `por_pulse_i` is 1, `mclr_n_i` is 0, or `bor_det_i` is 1 while `bor_cfg_i` is not 00.
- R2: When `pwrt_en_i` is 1, the power-up delay starts on the first clock edge at which `por_pulse_i` is low, and it then counts `PWRT_TICKS` cycles with `tick_i`=1. Ticks seen while the pulse is high do not count. With mclr high, no brown-out and a non-crystal mode, `core_rst_o` stays 1 for `PWRT_TICKS`+1 cycles after the pulse falls when a tick arrives every cycle.
- R3: Crystal modes are `clk_mode_i` 10 and 11. In these modes a start-up stage of `OST_CYCLES` cycles with `osc_stb_i`=1 follows the power-up delay. Strobes seen before that stage do not count. With ticks and strobes every cycle, reset lasts `PWRT_TICKS`+`OST_CYCLES`+1 cycles after the pulse falls.
- R4: Modes 00 (external clock) and 01 (internal oscillator) skip the start-up stage. With `pwrt_en_i`=0 and mode 00 there is no delay at all, and `core_rst_o` is high for exactly one cycle after the pulse falls.
- R5: Both delays run while `mclr_n_i` is low. If they have expired, `core_rst_o` falls in the same cycle that `mclr_n_i` rises.
- R6: A brown-out (with `bor_cfg_i` not 00) sends the sequence back to its start. After the brown-out clears, the full delay runs again. A master-clear reset on its own does not restart the delays.
- R7: With `bor_cfg_i`=00, `bor_det_i` has no effect: it does not assert reset, does not restart the delays, and does not change the brown-out flag.
- R8: `cause_rdata_o` bit 1 is the power-on flag and bit 0 is the brown-out flag, and bits 7..2 read as 0. A cycle with `cause_we_i`=1 loads `cause_wdata_i[1:0]` into the flags, and the new value is visible in the next cycle.
- R9: `por_pulse_i` clears the power-on flag. Master-clear and brown-out resets leave it unchanged. In this implementation the power-on pulse also clears the brown-out flag.
- R10: An enabled brown-out clears the brown-out flag. This takes priority over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_pulse_i | input | 1 | Power-on pulse, active high; also resets this block |
| bor_det_i | input | 1 | Brown-out detected, active high |
| bor_cfg_i | input | 2 | Brown-out enable configuration; 00 disables it |
| mclr_n_i | input | 1 | External master-clear, active low |
| pwrt_en_i | input | 1 | Power-up delay enable |
| clk_mode_i | input | 2 | Clock mode: 00 external, 01 internal, 10/11 crystal |
| tick_i | input | 1 | Slow timer tick, one cycle per period |
| osc_stb_i | input | 1 | Oscillator cycle strobe |
| cause_we_i | input | 1 | Cause register write strobe |
| cause_wdata_i | input | 8 | Cause register write data |
| cause_rdata_o | output | 8 | Cause register read data |
| core_rst_o | output | 1 | Internal core reset, active high |

## Verification
The bench aims at several off-by-one cases. It counts reset cycles exactly, so a design that counted a tick taken during the pulse, or that started the crystal stage early, would release one cycle too soon or too late. It holds master-clear low past both delays and then raises it. A design that restarted its timers on master-clear would keep reset asserted at that point. It sends a brown-out in the same cycle as a write of 1 to the brown-out flag, and sends brown-outs while they are disabled. A wrong priority or a missing enable gate would leave the flag at the wrong value or reset the core when it should not.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_PWRT = 2'd1,
    SEQ_OST  = 2'd2,
    SEQ_RUN  = 2'd3
  } seq_state_e;

  localparam int CAUSE_W = 8;
  localparam int POF_BIT = 1;
  localparam int BOF_BIT = 0;

  function automatic logic mode_is_crystal(input logic [1:0] mode);
    return mode[1];
  endfunction
endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic run_i,
  input  logic step_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // counter is held at zero whenever its stage is not active
  always_ff @(posedge clk_i) begin
    if (!run_i) cnt_q <= '0;
    else if (step_i && (cnt_q != LAST)) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i & step_i & (cnt_q == LAST);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       bor_act_i,
  input  logic       pwrt_en_i,
  input  logic       xtal_i,
  input  logic       pwrt_done_i,
  input  logic       ost_done_i,
  output seq_state_e state_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SEQ_HOLD: st_d = pwrt_en_i ? SEQ_PWRT : (xtal_i ? SEQ_OST : SEQ_RUN);
      SEQ_PWRT: if (pwrt_done_i) st_d = xtal_i ? SEQ_OST : SEQ_RUN;
      SEQ_OST:  if (ost_done_i) st_d = SEQ_RUN;
      default:  st_d = SEQ_RUN;
    endcase
    if (bor_act_i) st_d = SEQ_HOLD;
  end

  always_ff @(posedge clk_i) begin
    if (por_i) st_q <= SEQ_HOLD;
    else       st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/rst_seq_cause.sv
module rst_seq_cause (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       bor_act_i,
  input  logic       we_i,
  input  logic [1:0] wbits_i,
  output logic [1:0] flags_o
);
  logic pof_q, bof_q;

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      pof_q <= 1'b0;
      bof_q <= 1'b0;
    end else begin
      if (we_i) pof_q <= wbits_i[1];
      if (bor_act_i)  bof_q <= 1'b0;
      else if (we_i)  bof_q <= wbits_i[0];
    end
  end

  assign flags_o = {pof_q, bof_q};
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 64,
  parameter int OST_CYCLES = 1024
) (
  input  logic               clk_i,
  input  logic               por_pulse_i,
  input  logic               bor_det_i,
  input  logic [1:0]         bor_cfg_i,
  input  logic               mclr_n_i,
  input  logic               pwrt_en_i,
  input  logic [1:0]         clk_mode_i,
  input  logic               tick_i,
  input  logic               osc_stb_i,
  input  logic               cause_we_i,
  input  logic [CAUSE_W-1:0] cause_wdata_i,
  output logic [CAUSE_W-1:0] cause_rdata_o,
  output logic               core_rst_o
);
  seq_state_e state;
  logic       bor_act, xtal, pwrt_done, ost_done;
  logic [1:0] flags;

  assign bor_act = bor_det_i & (bor_cfg_i != 2'b00);
  assign xtal    = mode_is_crystal(clk_mode_i);

  rst_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .por_i       (por_pulse_i),
    .bor_act_i   (bor_act),
    .pwrt_en_i   (pwrt_en_i),
    .xtal_i      (xtal),
    .pwrt_done_i (pwrt_done),
    .ost_done_i  (ost_done),
    .state_o     (state)
  );

  rst_seq_timer #(.LIMIT(PWRT_TICKS)) u_pwrt (
    .clk_i    (clk_i),
    .run_i    (state == SEQ_PWRT),
    .step_i   (tick_i),
    .expire_o (pwrt_done)
  );

  generate
    if (OST_CYCLES > 0) begin : g_ost
      rst_seq_timer #(.LIMIT(OST_CYCLES)) u_ost (
        .clk_i    (clk_i),
        .run_i    (state == SEQ_OST),
        .step_i   (osc_stb_i),
        .expire_o (ost_done)
      );
    end else begin : g_no_ost
      assign ost_done = 1'b1;
    end
  endgenerate

  rst_seq_cause u_cause (
    .clk_i     (clk_i),
    .por_i     (por_pulse_i),
    .bor_act_i (bor_act),
    .we_i      (cause_we_i),
    .wbits_i   ({cause_wdata_i[POF_BIT], cause_wdata_i[BOF_BIT]}),
    .flags_o   (flags)
  );

  always_comb begin
    cause_rdata_o          = '0;
    cause_rdata_o[POF_BIT] = flags[1];
    cause_rdata_o[BOF_BIT] = flags[0];
  end

  assign core_rst_o = por_pulse_i | bor_act | ~mclr_n_i | (state != SEQ_RUN);
endmodule

// File: rtl/rst_seq_checker.sv
module rst_seq_checker (
  input logic       clk_i,
  input logic       por_pulse_i,
  input logic       bor_det_i,
  input logic [1:0] bor_cfg_i,
  input logic       mclr_n_i,
  input logic       cause_we_i,
  input logic [7:0] cause_rdata_o,
  input logic       core_rst_o
);
  AST_MCLR_HOLDS: assert property (@(posedge clk_i) disable iff (por_pulse_i)
    !mclr_n_i |-> core_rst_o); // R1

  AST_BOR_HOLDS: assert property (@(posedge clk_i) disable iff (por_pulse_i)
    (bor_det_i && bor_cfg_i != 2'b00) |-> core_rst_o); // R1

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (por_pulse_i)
    cause_rdata_o[7:2] == 6'd0); // R8

  AST_POF_KEEP: assert property (@(posedge clk_i) disable iff (por_pulse_i)
    !cause_we_i |=> $stable(cause_rdata_o[1])); // R9

  AST_BOF_CLEAR: assert property (@(posedge clk_i) disable iff (por_pulse_i)
    (bor_det_i && bor_cfg_i != 2'b00) |=> !cause_rdata_o[0]); // R10

  AST_BOR_OFF: assert property (@(posedge clk_i) disable iff (por_pulse_i)
    (bor_cfg_i == 2'b00 && !cause_we_i) |=> $stable(cause_rdata_o[0])); // R7
endmodule

bind rst_seq_top rst_seq_checker u_chk (
  .clk_i         (clk_i),
  .por_pulse_i   (por_pulse_i),
  .bor_det_i     (bor_det_i),
  .bor_cfg_i     (bor_cfg_i),
  .mclr_n_i      (mclr_n_i),
  .cause_we_i    (cause_we_i),
  .cause_rdata_o (cause_rdata_o),
  .core_rst_o    (core_rst_o)
);

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
  localparam int PW = 5;
  localparam int OS = 7;

  logic       clk = 1'b0;
  logic       por = 1'b1, bor = 1'b0, mclr = 1'b1, pwen = 1'b1;
  logic [1:0] bcfg = 2'b01, mode = 2'b00;
  logic       tick = 1'b0, stb = 1'b0, we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic       rst;

  int n_chk = 0, n_err = 0;
  bit chk_en = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  rst_seq_top #(.PWRT_TICKS(PW), .OST_CYCLES(OS)) dut_i (
    .clk_i(clk), .por_pulse_i(por), .bor_det_i(bor), .bor_cfg_i(bcfg),
    .mclr_n_i(mclr), .pwrt_en_i(pwen), .clk_mode_i(mode), .tick_i(tick),
    .osc_stb_i(stb), .cause_we_i(we), .cause_wdata_i(wd),
    .cause_rdata_o(rdata), .core_rst_o(rst)
  );

  // reference model built from the requirements
  int   m_ph = 0, m_cnt = 0;
  logic m_pof = 1'b0, m_bof = 1'b0;

  function automatic logic bor_on(logic b, logic [1:0] c);
    return b && (c != 2'b00);
  endfunction

  function automatic logic exp_rst();
    return por || bor_on(bor, bcfg) || !mclr || (m_ph != 3);
  endfunction

  always @(posedge clk) begin
    if (por) begin
      m_ph <= 0; m_cnt <= 0; m_pof <= 1'b0; m_bof <= 1'b0;
    end else begin
      if (we) m_pof <= wd[1];
      if (bor_on(bor, bcfg)) m_bof <= 1'b0;
      else if (we) m_bof <= wd[0];
      if (bor_on(bor, bcfg)) begin
        m_ph <= 0; m_cnt <= 0;
      end else begin
        case (m_ph)
          0: begin m_cnt <= 0; m_ph <= pwen ? 1 : (mode[1] ? 2 : 3); end
          1: if (tick) begin
               if (m_cnt == PW - 1) begin m_cnt <= 0; m_ph <= mode[1] ? 2 : 3; end
               else m_cnt <= m_cnt + 1;
             end
          2: if (stb) begin
               if (m_cnt == OS - 1) begin m_cnt <= 0; m_ph <= 3; end
               else m_cnt <= m_cnt + 1;
             end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, logic [7:0] got, logic [7:0] exp, string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    check(cur_req, {7'd0, rst}, {7'd0, exp_rst()}, "core reset");
    check("R8", rdata, {6'd0, m_pof, m_bof}, "cause read");
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic reset_high_cycles(output int n);
    n = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!rst) break;
      n++;
    end
  endtask

  task automatic do_por();
    cyc(); por = 1'b1; cyc(3); por = 1'b0;
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_err++;
    $display("FAIL watchdog: got hung expected finish");
    report();
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    tick = 1'b1; stb = 1'b1;
    cyc(3);
    @(negedge clk);
    check("R1", {7'd0, rst}, 8'd1, "reset during power-on pulse");
    check("R9", rdata, 8'h00, "flags after power-on");
    chk_en = 1'b1;

    // R2 delay length, ticks every cycle
    cur_req = "R2";
    cyc(); por = 1'b0;
    reset_high_cycles(n);
    check("R2", n[7:0], 8'(PW + 1), "power-up delay length");

    // R3 crystal adds oscillator stage
    cur_req = "R3"; mode = 2'b10;
    do_por();
    reset_high_cycles(n);
    check("R3", n[7:0], 8'(PW + OS + 1), "crystal delay length");

    // R4 no delay at all, then internal oscillator skips start-up
    cur_req = "R4"; mode = 2'b00; pwen = 1'b0;
    do_por();
    reset_high_cycles(n);
    check("R4", n[7:0], 8'd1, "no delay in external clock");
    mode = 2'b01; pwen = 1'b1;
    do_por();
    reset_high_cycles(n);
    check("R4", n[7:0], 8'(PW + 1), "internal osc skips start-up");

    // R5 master-clear held past expiry
    cur_req = "R5"; mode = 2'b11;
    cyc(); por = 1'b1; mclr = 1'b0; cyc(3); por = 1'b0;
    cyc(PW + OS + 10);
    mclr = 1'b1; #0;
    @(negedge clk);
    check("R5", {7'd0, rst}, 8'd0, "release at master-clear rise");

    // R6 master-clear only reset does not restart delays
    cur_req = "R6";
    cyc(); mclr = 1'b0; cyc(3); mclr = 1'b1;
    @(negedge clk);
    check("R6", {7'd0, rst}, 8'd0, "no restart after master-clear");
    // brown-out restarts the full sequence
    cyc(); bcfg = 2'b01; bor = 1'b1; cyc(2); bor = 1'b0;
    reset_high_cycles(n);
    check("R6", n[7:0], 8'(PW + OS + 1), "restart after brown-out");

    // R8 write and read-back
    cur_req = "R8";
    cyc(); we = 1'b1; wd = 8'hFF; cyc(); we = 1'b0;
    @(negedge clk);
    check("R8", rdata, 8'h03, "write all ones");

    // R7 brown-out disabled: no effect
    cur_req = "R7"; bcfg = 2'b00;
    cyc(); bor = 1'b1; cyc(4); bor = 1'b0;
    @(negedge clk);
    check("R7", {7'd0, rst}, 8'd0, "no reset when disabled");
    check("R7", rdata, 8'h03, "flag kept when disabled");

    // R9 power-on flag survives brown-out and master-clear
    cur_req = "R9"; bcfg = 2'b10;
    cyc(); bor = 1'b1; cyc(); bor = 1'b0; mclr = 1'b0; cyc(2); mclr = 1'b1;
    @(negedge clk);
    check("R9", rdata, 8'h02, "power-on flag kept");
    reset_high_cycles(n);
    do_por();
    @(negedge clk);
    check("R9", rdata, 8'h00, "power-on clears flag");
    reset_high_cycles(n);

    // R10 brown-out beats a same-cycle write
    cur_req = "R10";
    cyc(); we = 1'b1; wd = 8'h01; bor = 1'b1; cyc(); we = 1'b0; bor = 1'b0;
    @(negedge clk);
    check("R10", rdata, 8'h00, "brown-out over write");
    reset_high_cycles(n);

    // random mix against the model
    cur_req = "R1";
    for (int i = 0; i < 4000; i++) begin
      cyc();
      por  = ($urandom % 400) == 0;
      bor  = ($urandom % 120) == 0;
      if (($urandom % 200) == 0) bcfg = 2'($urandom);
      if (($urandom % 300) == 0) mode = 2'($urandom);
      if (($urandom % 300) == 0) pwen = 1'($urandom);
      mclr = ($urandom % 25) != 0;
      tick = ($urandom % 3) == 0;
      stb  = ($urandom % 2) == 0;
      we   = ($urandom % 10) == 0;
      wd   = 8'($urandom);
    end
    cyc();
    chk_en = 1'b0;
    report();
  end
endmodule